// File: doc/BRIEF.md
# Synchronous burst-read WAIT generator

This block is the read side of a synchronous burst memory port. A one-cycle `start` pulse latches a start address together with the burst configuration. After a programmable first-access latency, the block drives one data word per clock. The word comes from a simple computed lookup of its address. A WAIT output flags every clock in which no valid word is presented. These are the initial latency cycles and a single stall in mid-burst.

In linear addressing, the block may insert one stall when the burst first crosses a 16-word row boundary. Linear addressing means either a fixed-length burst with the no-wrap bit set, or a continuous burst. The stall length depends on where the start address sits inside its 4-word group. A start on a 4-word boundary never stalls, and a start on the last word of a group gives the worst case. WAIT can be shown in the stalled cycle itself or one cycle ahead of it. Its active level is programmable.

The controller has four states:
- `ST_IDLE`: the burst is waiting for `start`.
- `ST_LAT`: first-access latency.
- `ST_DATA`: a valid word is on the bus.
- `ST_STALL`: boundary stall.

It has these transitions:
- IDLE→LAT on `start`.
- LAT→DATA when the latency count expires.
- DATA→STALL when the row-end word is shown and a stall is still owed.
- STALL→DATA when the stall count expires.
- DATA→IDLE after the last word of a fixed-length burst.
- LAT/DATA/STALL→IDLE on `stop`.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset, `busy` and `dout_valid` are 0, `dout` is 0, and `wait_o` sits at its inactive level.
- R2: `start` is sampled only in IDLE. Let L be `cfg_latency`, where values 0 and 1 act as 2. The first valid word appears in the L-th cycle after the sampling edge, and the cycles between carry no valid word.
- R3: `cfg_len` encodes the burst: 0 gives 4 words, 1 gives 8, 2 gives 16, and 3 gives a continuous burst. A fixed burst returns to IDLE after its last valid word, and `busy` is 1 from the sampling edge until then.
- R4: A valid word equals the zero-extended word address XOR `DATA_SEED` (default 16'h3C00). `dout` is 0 whenever `dout_valid` is 0.
- R5: In linear mode, addresses rise by one per valid word, modulo 2^ADDR_W. Linear mode is `cfg_nowrap`=1 with a fixed length, or any continuous burst.
- R6: In wrap mode (`cfg_nowrap`=0 with a fixed length), addresses step within the window of burst-length size that is aligned on that size, and no stall is ever inserted.
- R7: In linear mode, take the start offset o = `start_addr[1:0]`. If o≠0 and the burst continues past an address whose low four bits are 15, then `dout_valid` drops for S cycles right after that word. S is L-1 for o=3, and min(o, L-1) otherwise. Then the burst resumes at the next address, with no word skipped, and this happens at most once per burst.
- R8: A start offset of 0, or a burst that never passes a row end, gives no stall.
- R9: With `cfg_wait_early`=0, WAIT is active in exactly the busy cycles without a valid word. With `cfg_wait_early`=1, WAIT is active in a busy cycle exactly when the following cycle is a busy cycle without a valid word.
- R10: `cfg_wait_pol`=1 makes WAIT active-high and 0 makes it active-low. WAIT is inactive when not busy.
- R11: `stop` ends any burst at the next edge. A `start` raised while busy is ignored, and the running burst continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (sampled in IDLE) |
| start_addr | input | ADDR_W | Burst start word address |
| stop | input | 1 | Terminate the current burst |
| cfg_len | input | 2 | Burst length code |
| cfg_nowrap | input | 1 | 1 = linear, 0 = wrap within burst window |
| cfg_wait_early | input | 1 | 1 = WAIT one cycle ahead of the affected cycle |
| cfg_wait_pol | input | 1 | 1 = WAIT active-high |
| cfg_latency | input | LAT_W | First-access latency in clocks (2..7) |
| dout | output | DATA_W | Data word |
| dout_valid | output | 1 | Data word valid |
| wait_o | output | 1 | WAIT handshake |
| busy | output | 1 | A burst is in progress |

## Verification
Aligned linear bursts of 4 and 16 words separate the plain latency and ordering behaviour from the stall. A wrap-mode burst that starts mid-window shows that wrapping replaces the row crossing and never stalls. Starts at offsets 1, 2 and 3 that cross a row, at several latencies, tell the min(o, L-1) rule apart from the L-1 worst case. An aligned crossing and an unaligned non-crossing burst show both conditions are needed. A long continuous burst crosses two rows to prove the stall is one-time. It also runs with early, active-low WAIT and ends by `stop`, with a stray `start` mid-burst and a latency code below 2 covering the remaining rules.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LAT   = 2'd1,
        ST_DATA  = 2'd2,
        ST_STALL = 2'd3
    } bwg_state_e;

    typedef enum logic [1:0] {
        LEN_4    = 2'd0,
        LEN_8    = 2'd1,
        LEN_16   = 2'd2,
        LEN_CONT = 2'd3
    } bwg_len_e;

    localparam int ROW_WORDS  = 16;
    localparam int CNT_W      = 5;

    function automatic logic [CNT_W-1:0] len_words(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'd0:    n = CNT_W'(4);
            2'd1:    n = CNT_W'(8);
            2'd2:    n = CNT_W'(16);
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bwg_stall_calc.sv
module bwg_stall_calc #(
    parameter int LAT_W = 3
) (
    input  logic [1:0]       offset,
    input  logic [LAT_W-1:0] lat_eff,
    output logic [LAT_W-1:0] stall_len
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);
    localparam logic [LAT_W-1:0] TWO = LAT_W'(2);

    logic [LAT_W-1:0] lat_m1;

    always_comb begin
        lat_m1 = lat_eff - ONE;
        unique case (offset)
            2'd0:    stall_len = '0;
            2'd1:    stall_len = ONE;
            2'd2:    stall_len = (lat_m1 < TWO) ? lat_m1 : TWO;
            default: stall_len = lat_m1;
        endcase
    end
endmodule

// File: rtl/bwg_addr_step.sv
module bwg_addr_step #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wrap_en,
    input  logic [1:0]        len_code,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;

    always_comb begin
        unique case (len_code)
            2'd0:    mask = ADDR_W'(3);
            2'd1:    mask = ADDR_W'(7);
            default: mask = ADDR_W'(15);
        endcase
        inc = cur + ADDR_W'(1);
        if (wrap_en)
            nxt = (cur & ~mask) | (inc & mask);
        else
            nxt = inc;
    end
endmodule

// File: rtl/bwg_wait_out.sv
module bwg_wait_out
    import bwg_pkg::*;
(
    input  bwg_state_e state,
    input  bwg_state_e next_state,
    input  logic       early,
    input  logic       pol,
    output logic       wait_o
);
    logic act_now;
    logic act_ahead;
    logic act;

    always_comb begin
        act_now   = (state == ST_LAT) || (state == ST_STALL);
        act_ahead = (state != ST_IDLE) &&
                    ((next_state == ST_LAT) || (next_state == ST_STALL));
        act       = early ? act_ahead : act_now;
        wait_o    = pol ? act : ~act;
    end
endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
    import bwg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 3,
    parameter logic [DATA_W-1:0] DATA_SEED = 16'h3C00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              stop,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_nowrap,
    input  logic              cfg_wait_early,
    input  logic              cfg_wait_pol,
    input  logic [LAT_W-1:0]  cfg_latency,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              wait_o,
    output logic              busy
);
    localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(2);
    localparam logic [LAT_W-1:0] L_ONE   = LAT_W'(1);
    localparam logic [CNT_W-1:0] W_ONE   = CNT_W'(1);
    localparam int               ROW_LSB = $clog2(ROW_WORDS);

    bwg_state_e        state, next_state;
    logic [ADDR_W-1:0] cur_addr, base_r, addr_nxt;
    logic [LAT_W-1:0]  lat_cnt, stall_cnt, stall_len_r, stall_len_c, lat_eff;
    logic [CNT_W-1:0]  words_left;
    logic [1:0]        len_r;
    logic              wrap_r, cont_r, early_r, stall_done;
    logic              last_word, stall_hit;

    assign lat_eff = (cfg_latency < LAT_MIN) ? LAT_MIN : cfg_latency;

    bwg_stall_calc #(.LAT_W(LAT_W)) u_stall (
        .offset    (start_addr[1:0]),
        .lat_eff   (lat_eff),
        .stall_len (stall_len_c)
    );

    bwg_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur      (cur_addr),
        .wrap_en  (wrap_r),
        .len_code (len_r),
        .nxt      (addr_nxt)
    );

    always_comb begin
        last_word = !cont_r && (words_left == W_ONE);
        stall_hit = !wrap_r && !stall_done && (stall_len_r != '0) &&
                    (cur_addr[ROW_LSB-1:0] == {ROW_LSB{1'b1}});
    end

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:  if (start) next_state = ST_LAT;
            ST_LAT: begin
                if (stop)                 next_state = ST_IDLE;
                else if (lat_cnt == L_ONE) next_state = ST_DATA;
            end
            ST_DATA: begin
                if (stop || last_word)    next_state = ST_IDLE;
                else if (stall_hit)       next_state = ST_STALL;
            end
            ST_STALL: begin
                if (stop)                   next_state = ST_IDLE;
                else if (stall_cnt == L_ONE) next_state = ST_DATA;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // burst datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr    <= '0;
            base_r      <= '0;
            lat_cnt     <= '0;
            stall_cnt   <= '0;
            stall_len_r <= '0;
            words_left  <= '0;
            len_r       <= '0;
            wrap_r      <= 1'b0;
            cont_r      <= 1'b0;
            early_r     <= 1'b0;
            stall_done  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cur_addr    <= start_addr;
                    base_r      <= start_addr;
                    lat_cnt     <= lat_eff - L_ONE;
                    stall_len_r <= stall_len_c;
                    words_left  <= len_words(cfg_len);
                    len_r       <= cfg_len;
                    cont_r      <= (cfg_len == LEN_CONT);
                    wrap_r      <= !cfg_nowrap && (cfg_len != LEN_CONT);
                    early_r     <= cfg_wait_early;
                    stall_done  <= 1'b0;
                end
                ST_LAT:  lat_cnt <= lat_cnt - L_ONE;
                ST_DATA: if (next_state != ST_IDLE) begin
                    cur_addr <= addr_nxt;
                    if (!cont_r) words_left <= words_left - W_ONE;
                    if (next_state == ST_STALL) begin
                        stall_cnt  <= stall_len_r;
                        stall_done <= 1'b1;
                    end
                end
                ST_STALL: stall_cnt <= stall_cnt - L_ONE;
            endcase
        end
    end

    // outputs
    bwg_wait_out u_wait (
        .state      (state),
        .next_state (next_state),
        .early      (early_r),
        .pol        (cfg_wait_pol),
        .wait_o     (wait_o)
    );

    always_comb begin
        busy       = (state != ST_IDLE);
        dout_valid = (state == ST_DATA);
        dout       = dout_valid ? (DATA_W'(cur_addr) ^ DATA_SEED) : '0;
    end

    // assertions
    AST_START_ENTERS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_LAT)); // R2
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !stop && start) |=> $stable(base_r)); // R11
    AST_STALL_AT_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && next_state == ST_STALL) |-> (cur_addr[3:0] == 4'hF && !stall_done)); // R7
    AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && $past(state) == ST_STALL) |-> $stable(cur_addr)); // R7
    AST_ALIGNED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |-> (base_r[1:0] != 2'd0)); // R8
    AST_WRAP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_r |-> (state != ST_STALL)); // R6
    AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && wrap_r) |-> (cur_addr[ADDR_W-1:4] == base_r[ADDR_W-1:4])); // R6
    AST_VALID_NOT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !early_r) |-> (wait_o == !cfg_wait_pol)); // R9
    AST_IDLE_WAIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wait_o == !cfg_wait_pol && !dout_valid)); // R10
endmodule

// File: tb/tb_burst_wait_gen.sv
module tb_burst_wait_gen;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int LAT_W  = 3;
    localparam logic [15:0] SEED = 16'h3C00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              stop = 1'b0;
    logic [1:0]        cfg_len = '0;
    logic              cfg_nowrap = 1'b1;
    logic              cfg_wait_early = 1'b0;
    logic              cfg_wait_pol = 1'b1;
    logic [LAT_W-1:0]  cfg_latency = 3'd4;
    logic [DATA_W-1:0] dout;
    logic              dout_valid;
    logic              wait_o;
    logic              busy;

    int errors = 0;
    int checks = 0;
    bit qv[$];
    int qa[$];

    always #10 clk = ~clk;

    burst_wait_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .stop(stop), .cfg_len(cfg_len), .cfg_nowrap(cfg_nowrap),
        .cfg_wait_early(cfg_wait_early), .cfg_wait_pol(cfg_wait_pol),
        .cfg_latency(cfg_latency), .dout(dout), .dout_valid(dout_valid),
        .wait_o(wait_o), .busy(busy)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(busy == 1'b0, {tag, " busy"}, busy, 0);
        chk(dout_valid == 1'b0, {tag, " valid"}, dout_valid, 0);
        chk(dout == '0, {tag, " dout"}, dout, 0);
        chk(wait_o == !cfg_wait_pol, {tag, " R10 wait idle"}, wait_o, !cfg_wait_pol);
    endtask

    // reference model: per-cycle list of (valid, address)
    task automatic run_burst(input int sa, input int len, input bit nowrap,
                             input bit early, input int lat, input int ncont, input bit ign);
        int le   = (lat < 2) ? 2 : lat;
        int nw   = (len == 0) ? 4 : (len == 1) ? 8 : (len == 2) ? 16 : ncont;
        bit wrap = !nowrap && (len != 3);
        int off  = sa & 3;
        int stl  = (off == 0) ? 0 : (off == 3) ? le - 1 : ((off < le - 1) ? off : le - 1);
        int a    = sa;
        bit done = 0;
        int n;
        qv.delete();
        qa.delete();
        repeat (le - 1) begin qv.push_back(0); qa.push_back(0); end
        for (int i = 0; i < nw; i++) begin
            qv.push_back(1);
            qa.push_back(a);
            if (wrap) begin
                int m = (len == 0) ? 3 : (len == 1) ? 7 : 15;
                a = (a & ~m) | ((a + 1) & m);
            end else begin
                if ((a & 15) == 15 && !done && stl > 0 && i < nw - 1) begin
                    repeat (stl) begin qv.push_back(0); qa.push_back(0); end
                    done = 1;
                end
                a = (a + 1) & 255;
            end
        end
        n = qv.size();
        @(posedge clk); #2;
        start_addr = ADDR_W'(sa); cfg_len = 2'(len); cfg_nowrap = nowrap;
        cfg_wait_early = early; cfg_latency = LAT_W'(lat); start = 1'b1;
        for (int k = 0; k < n; k++) begin
            bit act;
            @(posedge clk); #2;
            start = (ign && k == 2);
            if (ign && k == 2) start_addr = ~ADDR_W'(sa);
            stop = (len == 3) && (k == n - 1);
            @(negedge clk);
            act = early ? ((k + 1 < n) && !qv[k + 1]) : !qv[k];
            chk(busy == 1'b1, "R3 R11 busy during burst", busy, 1);
            chk(dout_valid == qv[k], "R2 R7 R8 valid", dout_valid, qv[k]);
            if (qv[k])
                chk(dout == (16'(qa[k]) ^ SEED), "R4 R5 R6 data", dout, 16'(qa[k]) ^ SEED);
            else
                chk(dout == '0, "R4 dout idle word", dout, 0);
            chk(wait_o == (cfg_wait_pol ? act : !act), "R9 R10 wait", wait_o,
                cfg_wait_pol ? act : !act);
        end
        @(posedge clk); #2;
        stop = 1'b0;
        start = 1'b0;
        @(negedge clk);
        check_idle("R3 R11 end");
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset");
        run_burst(8'h10, 0, 1, 0, 4, 0, 1);   // R2 R3 R5 aligned, stray start (R11)
        run_burst(8'h25, 1, 0, 0, 3, 0, 0);   // R6 wrap, mid-window
        run_burst(8'h0B, 2, 1, 0, 5, 0, 0);   // R7 offset 3 worst case
        run_burst(8'h0D, 1, 1, 1, 3, 0, 0);   // R7 offset 1, early WAIT (R9)
        run_burst(8'h1E, 1, 1, 0, 2, 0, 0);   // R7 offset 2 capped at L-1
        run_burst(8'h2E, 2, 1, 1, 6, 0, 0);   // R7 offset 2 uncapped
        run_burst(8'h0C, 2, 1, 0, 4, 0, 0);   // R8 aligned crossing
        run_burst(8'h21, 0, 1, 0, 4, 0, 0);   // R8 no crossing
        @(posedge clk); #2 cfg_wait_pol = 1'b0;
        @(negedge clk);
        check_idle("R10 low polarity");
        run_burst(8'h36, 3, 1, 1, 7, 30, 0);  // R3 continuous, R7 once, R10
        run_burst(8'h40, 0, 1, 0, 1, 0, 0);   // R2 latency code 1 acts as 2
        run_burst(8'hFF, 1, 1, 0, 3, 0, 0);   // R5 address rolls over, offset 3 stall
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule